// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with FIFOs

This block is a full-duplex serial port that moves 8-bit characters over a three-wire synchronous link: one serial clock it generates itself, one transmit data line and one receive data line. The host side talks to two 16-entry character queues. It pushes bytes into the transmit queue and pops bytes from the receive queue. A set of status outputs reports how full each queue is and whether the line has gone quiet.

Whenever the transmit queue holds a character, the engine pulls it out and clocks it onto the line, least significant bit first. Transmit bits change on falling serial-clock edges. On each rising edge the receive line is sampled, so every transmitted character also gathers one received character. If the transmit queue still holds data when a character ends, the serial clock keeps running with no gap. Otherwise the clock parks high and the data line keeps the last bit sent. The `half_period_i` input sets the serial clock half-period in system clocks. A value of 0 is treated as 1.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the serial clock is high, the transmit line is high, both queue counts are 0, tx_empty_o and tx_idle_o are 1, and rx_avail_o, tx_overflow_o and rx_overrun_o are 0.
- R2: Each character is 8 bits, sent bit 0 first and bit 7 last. The transmit line changes only in the cycle in which the serial clock falls, so it is stable at every rising edge.
- R3: The receive line is sampled on each rising serial-clock edge, LSB first. After the 8th rising edge of a character, the assembled byte enters the receive queue. Receiving runs at the same time as transmitting.
- R4: While a transfer runs, every low phase and every high phase of the serial clock lasts max(half_period_i,1) system clocks. This also holds for the high phase between two characters when the next one is already queued.
- R5: While no character is being shifted, the serial clock stays high.
- R6: After the last queued character, the transmit line keeps the value of that character's bit 7.
- R7: The transmit queue holds up to 16 bytes. tx_level_o gives its fill level and tx_empty_o flags level 0. A push while the level is 16 is discarded and sets tx_overflow_o, which stays set until reset.
- R8: The receive queue holds up to 16 bytes. rx_level_o gives its fill level and rx_avail_o flags a level above 0. A byte that completes while the queue is full is discarded and sets rx_overrun_o, which stays set until reset.
- R9: rx_data_o shows the oldest received byte. While the receive queue is empty it reads 0, and a pop leaves the queue unchanged.
- R10: tx_idle_o is 1 exactly when the transmit queue is empty and the final high phase of the last character has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period_i | input | 8 | Serial clock half-period in system clocks (0 behaves as 1) |
| tx_push_i | input | 1 | Write tx_byte_i into the transmit queue |
| tx_byte_i | input | 8 | Byte to transmit |
| rx_pop_i | input | 1 | Remove the oldest byte from the receive queue |
| rx_data_o | output | 8 | Oldest received byte, 0 when the queue is empty |
| tx_level_o | output | 5 | Transmit queue fill level |
| rx_level_o | output | 5 | Receive queue fill level |
| tx_empty_o | output | 1 | Transmit queue is empty |
| rx_avail_o | output | 1 | Receive queue holds at least one byte |
| tx_idle_o | output | 1 | Transmit queue empty and line finished |
| tx_overflow_o | output | 1 | Sticky: a push hit a full transmit queue |
| rx_overrun_o | output | 1 | Sticky: a received byte was dropped |
| sclk_o | output | 1 | Serial clock, rests high |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The assertions check, on every cycle, the properties that any single cycle can show. The transmit line moves only together with a falling serial clock. The clock is high whenever the port is idle. The queue levels never pass their depth. Both error flags stay set once raised. An empty receive queue reads as zero. Bit order, phase lengths, continuous clocking between characters, and the holding of bit 7 depend on a whole character or on a sequence of characters. The overflow and overrun points depend on how many bytes are in flight. Only the bench scenarios can show these, by rebuilding each character at the serial pins and comparing it with a scoreboard.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign count_o = cnt_q;
  assign data_o  = empty_o ? '0 : mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = wptr_q + 1'b1;
    if (do_pop)  rptr_d = rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/ssp_halfper.sv
module ssp_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lim, cnt_q, cnt_d;

  assign lim    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o = run_i & (cnt_q == lim - 1'b1);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         txq_empty_i,
  input  logic [W-1:0] txq_data_i,
  input  logic         rxd_i,
  output logic         txq_pop_o,
  output logic         rxq_push_o,
  output logic [W-1:0] rxq_data_o,
  output logic         sclk_o,
  output logic         txd_o,
  output logic         busy_o
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  eng_state_e    st_q, st_d;
  logic          sclk_q, sclk_d, txd_q, txd_d;
  logic [W-1:0]  tsh_q, tsh_d, rsh_q, rsh_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          load, shift_en, sample_en;

  assign busy_o     = (st_q == ENG_RUN);
  assign sclk_o     = sclk_q;
  assign txd_o      = txd_q;
  assign rxq_data_o = {rxd_i, rsh_q[W-1:1]};

  always_comb begin
    st_d       = st_q;
    sclk_d     = sclk_q;
    txd_d      = txd_q;
    idx_d      = idx_q;
    load       = 1'b0;
    shift_en   = 1'b0;
    sample_en  = 1'b0;
    rxq_push_o = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (!txq_empty_i) begin
          load = 1'b1;
          st_d = ENG_RUN;
        end
      end
      ENG_RUN: begin
        if (tick_i) begin
          if (!sclk_q) begin
            sclk_d     = 1'b1;
            sample_en  = 1'b1;
            rxq_push_o = (idx_q == LAST);
          end else if (idx_q != LAST) begin
            shift_en = 1'b1;
          end else if (!txq_empty_i) begin
            load = 1'b1;
          end else begin
            st_d = ENG_IDLE;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
    if (load) begin
      sclk_d = 1'b0;
      txd_d  = txq_data_i[0];
      idx_d  = '0;
    end
    if (shift_en) begin
      sclk_d = 1'b0;
      txd_d  = tsh_q[1];
      idx_d  = idx_q + 1'b1;
    end
    txq_pop_o = load;
    tsh_d = load ? txq_data_i : {1'b0, tsh_q[W-1:1]};
    rsh_d = {rxd_i, rsh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      sclk_q <= 1'b1;
      txd_q  <= 1'b1;
      idx_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      txd_q  <= txd_d;
      idx_q  <= idx_d;
      if (load || shift_en) tsh_q <= tsh_d;
      if (sample_en)        rsh_q <= rsh_d;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [CNT_W-1:0]  tx_level_o,
  output logic [CNT_W-1:0]  rx_level_o,
  output logic              tx_empty_o,
  output logic              rx_avail_o,
  output logic              tx_idle_o,
  output logic              tx_overflow_o,
  output logic              rx_overrun_o,
  output logic              sclk_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              eng_pop, eng_push, eng_busy, tick;
  logic [DATA_W-1:0] txq_head, rx_byte;
  logic              ovf_q, ovf_d, ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n),
    .push_i(tx_push_i), .data_i(tx_byte_i), .pop_i(eng_pop),
    .data_o(txq_head), .count_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n),
    .push_i(eng_push), .data_i(rx_byte), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .count_o(rx_level_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  ssp_halfper #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .run_i(eng_busy),
    .div_i(half_period_i), .tick_o(tick)
  );

  ssp_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick),
    .txq_empty_i(tx_empty), .txq_data_i(txq_head), .rxd_i(rxd_i),
    .txq_pop_o(eng_pop), .rxq_push_o(eng_push), .rxq_data_o(rx_byte),
    .sclk_o(sclk_o), .txd_o(txd_o), .busy_o(eng_busy)
  );

  always_comb begin
    ovf_d = ovf_q | (tx_push_i & tx_full);
    ovr_d = ovr_q | (eng_push & rx_full);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      ovr_q <= ovr_d;
    end
  end

  assign tx_empty_o    = tx_empty;
  assign rx_avail_o    = ~rx_empty;
  assign tx_idle_o     = tx_empty & ~eng_busy;
  assign tx_overflow_o = ovf_q;
  assign rx_overrun_o  = ovr_q;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          txd,
  input logic          tx_idle,
  input logic          tx_empty,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          rx_avail,
  input logic [W-1:0]  rx_data,
  input logic          tx_ovf,
  input logic          rx_ovr
);
  AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $fell(sclk)); // R2
  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> sclk); // R5
  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH)); // R7
  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R7
  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH)); // R8
  AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> rx_ovr); // R8
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> (rx_data == '0)); // R9
  AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_empty); // R10
endmodule

bind sync_serial_port ssp_checker #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_ssp_checker (
  .clk(clk), .rst_n(rst_n), .sclk(sclk_o), .txd(txd_o), .tx_idle(tx_idle_o),
  .tx_empty(tx_empty_o), .tx_level(tx_level_o), .rx_level(rx_level_o),
  .rx_avail(rx_avail_o), .rx_data(rx_data_o), .tx_ovf(tx_overflow_o), .rx_ovr(rx_overrun_o)
);

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [7:0] half_period_i;
  logic       tx_push_i, rx_pop_i, rxd_i;
  logic [7:0] tx_byte_i, rx_data_o;
  logic [4:0] tx_level_o, rx_level_o;
  logic       tx_empty_o, rx_avail_o, tx_idle_o, tx_overflow_o, rx_overrun_o, sclk_o, txd_o;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .half_period_i(half_period_i),
    .tx_push_i(tx_push_i), .tx_byte_i(tx_byte_i), .rx_pop_i(rx_pop_i),
    .rx_data_o(rx_data_o), .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
    .tx_empty_o(tx_empty_o), .rx_avail_o(rx_avail_o), .tx_idle_o(tx_idle_o),
    .tx_overflow_o(tx_overflow_o), .rx_overrun_o(rx_overrun_o),
    .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit mon_on   = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_model[$];
  bit         ovf_exp = 1'b0;
  bit         ovr_exp = 1'b0;
  logic [7:0] last_tx;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    if (tx_level_o == 5'd16) ovf_exp = 1'b1;
    else begin
      tx_q.push_back(b);
      last_tx = b;
    end
    tx_push_i = 1'b1;
    tx_byte_i = b;
    @(posedge clk);
    #1 tx_push_i = 1'b0;
  endtask

  task automatic pop_check();
    logic [7:0] e;
    @(negedge clk);
    if (rx_model.size() == 0) begin
      check(rx_data_o == 8'h00, "R9", "empty read value", rx_data_o, 0);
    end else begin
      e = rx_model.pop_front();
      check(rx_data_o == e, "R3", "received byte", rx_data_o, e);
    end
    rx_pop_i = 1'b1;
    @(posedge clk);
    #1 rx_pop_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_idle_o) @(negedge clk);
  endtask

  // Monitor: rebuilds characters at the pins, drives rxd on falling edges
  initial begin
    logic       prev;
    int         plen, rise_n, fall_n, rx_idx;
    bit         from_idle;
    logic [7:0] cap, rx_cur, e;
    prev = 1'b1; plen = 0; rise_n = 0; fall_n = 0; rx_idx = 0;
    from_idle = 1'b1; cap = '0; rx_cur = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (tx_idle_o) from_idle = 1'b1;
        if (sclk_o != prev) begin
          if (sclk_o) begin
            check(plen == int'(half_period_i), "R4", "low phase length", plen, half_period_i);
            cap = {txd_o, cap[7:1]};
            rise_n++;
            if (rise_n == 8) begin
              rise_n = 0;
              if (tx_q.size() == 0) check(1'b0, "R2", "unexpected character", cap, 0);
              else begin
                e = tx_q.pop_front();
                check(cap == e, "R2", "transmitted byte", cap, e);
              end
              if (rx_model.size() < 16) rx_model.push_back(rx_cur);
              else ovr_exp = 1'b1;
            end
          end else begin
            if (!from_idle)
              check(plen == int'(half_period_i), "R4", "high phase between bits", plen, half_period_i);
            from_idle = 1'b0;
            if (fall_n == 0) begin
              rx_cur = 8'h3C ^ 8'(rx_idx * 29);
              rx_idx++;
            end
            rxd_i  = rx_cur[fall_n];
            fall_n = (fall_n + 1) % 8;
          end
          plen = 1;
        end else plen++;
        prev = sclk_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_push_i = 1'b0; rx_pop_i = 1'b0; rxd_i = 1'b1;
    tx_byte_i = '0; half_period_i = 8'd1; last_tx = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sclk_o == 1'b1, "R1", "sclk after reset", sclk_o, 1);
    check(txd_o == 1'b1, "R1", "txd after reset", txd_o, 1);
    check(tx_level_o == 0 && rx_level_o == 0, "R1", "levels after reset", tx_level_o + rx_level_o, 0);
    check(tx_empty_o && tx_idle_o && !rx_avail_o, "R1", "flags after reset",
          {tx_empty_o, tx_idle_o, rx_avail_o}, 3'b110);
    check(!tx_overflow_o && !rx_overrun_o, "R1", "error flags after reset",
          {tx_overflow_o, rx_overrun_o}, 0);
    mon_on = 1'b1;

    // Back-to-back at the fastest rate (R2, R3, R4)
    push_byte(8'hA5); push_byte(8'h0F); push_byte(8'h96);
    repeat (3) @(negedge clk);
    check(!tx_idle_o, "R10", "idle while shifting", tx_idle_o, 0);
    wait_idle();
    check(tx_q.size() == 0, "R2", "all characters seen", tx_q.size(), 0);
    check(txd_o == last_tx[7], "R6", "line holds bit 7", txd_o, last_tx[7]);
    check(rx_level_o == 3, "R8", "rx level", rx_level_o, 3);
    check(rx_avail_o, "R8", "rx available", rx_avail_o, 1);
    repeat (3) pop_check();

    // Slower rate, with a gap between groups (R4, R5, R6)
    half_period_i = 8'd3;
    push_byte(8'h81); push_byte(8'h7E);
    wait_idle();
    check(txd_o == last_tx[7], "R6", "line holds bit 7 after 0x7E", txd_o, last_tx[7]);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(sclk_o == 1'b1, "R5", "clock rests high", sclk_o, 1);
    end
    push_byte(8'hC3); push_byte(8'h00); push_byte(8'hFF);
    wait_idle();
    check(txd_o == last_tx[7], "R6", "line holds bit 7 after 0xFF", txd_o, last_tx[7]);
    check(tx_idle_o && tx_empty_o, "R10", "idle after drain", tx_idle_o, 1);
    repeat (5) pop_check();
    check(!tx_overflow_o && !rx_overrun_o, "R7", "no error yet",
          {tx_overflow_o, rx_overrun_o}, 0);

    // Fill the transmit queue, then overflow both queues (R7, R8, R9)
    half_period_i = 8'd4;
    for (int i = 0; i < 18; i++) push_byte(8'(8'h11 * i + 8'h05));
    @(negedge clk);
    check(tx_level_o == 16, "R7", "tx level when full", tx_level_o, 16);
    check(tx_overflow_o == ovf_exp, "R7", "overflow flag", tx_overflow_o, ovf_exp);
    wait_idle();
    check(tx_q.size() == 0, "R7", "accepted characters sent", tx_q.size(), 0);
    check(rx_level_o == 16, "R8", "rx level when full", rx_level_o, 16);
    check(rx_overrun_o == ovr_exp && ovr_exp, "R8", "overrun flag", rx_overrun_o, 1);
    check(tx_overflow_o == 1'b1, "R7", "overflow stays set", tx_overflow_o, 1);
    repeat (16) pop_check();
    pop_check();
    @(negedge clk);
    check(rx_level_o == 0, "R9", "empty pop leaves level", rx_level_o, 0);
    check(rx_data_o == 8'h00, "R9", "empty read stays zero", rx_data_o, 0);
    check(rx_overrun_o == 1'b1, "R8", "overrun stays set", rx_overrun_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule